// File: doc/BRIEF.md
# Analog-Input Scan-List Sequencer

This block sits between a 16-bit register bus and an analog-to-digital converter. Software writes channel configurations into a scan-list FIFO one byte at a time, two bytes per 16-bit entry and four entries per channel. A start command lets the sequencer move one configuration at a time into a config pipe. While the pacer is enabled, a pacer tick starts a conversion. The tick is taken only when the pipe is full and scanning is active. At the tick, the block drives the channel, gain and bank selects and pulses the converter start line.

When the converter signals done, its result is pushed into a results FIFO, and software pops samples from there by reading a register. An entry whose second word carries the last flag ends the scan. After that entry no further conversions occur until the pacer is disabled, the scan is stopped or the pipe is reset.

The results path is register-mapped, not streamed. A read of the results address is the consumer's handshake: it pops one sample if one is present. The only back-pressure is the overrun flag, which is set when a conversion completes into a full FIFO.

Top module: `acq_scan_seq`

## Requirements
- R1: A scan-list entry is written as two writes to address 0x02, low byte first and then high byte, with only bus_wdata[7:0] taken from each write. Four consecutive entries form one channel configuration, word0 to word3.
- R2: Control value 0x0011, written to address 0x00, starts moving scan-list entries into the config pipe. Status bit 4 (pipe full) is set once all four words of a configuration are loaded. Control value 0x0010 stops the scan.
- R3: A control value with bits [15:3] all zero is a reset command. Bit 2 clears the scan-list FIFO and any pending low byte. Bit 1 clears the results FIFO and the overrun flag. Bit 0 clears the config pipe and the scanning state.
- R4: Control value 0x0031 enables the pacer and 0x0030 disables it. The divider D is written at three addresses: bits [15:0] at 0x04, bits [31:16] at 0x06 and bits [47:32] at 0x0A. While enabled, the pacer ticks once every D+1 clock cycles.
- R5: Scanning (status bit 3) becomes active when the pacer is enabled while the pipe is full. Pacer ticks are ignored unless the pipe is full and scanning is active.
- R6: An accepted tick produces a one-cycle adc_start pulse and registers the selects in the same cycle. sel_chan comes from word2[7:6]. sel_bank_lo comes from word3[0], sel_bank_hi from word3[1], sel_hilo from word3[2], sel_gain from word3[5:3] and sel_single from word3[6].
- R7: adc_done during a pending conversion pushes adc_data into the results FIFO. adc_done with no pending conversion is ignored.
- R8: When word1[2] is set, the entry is the last one. After its conversion, scanning clears and no further adc_start occurs. Otherwise the next configuration is loaded and converted on a later tick.
- R9: A read of address 0x10 pops one result, and the value appears on bus_rdata one cycle after the read strobe. A read of an empty results FIFO returns 0.
- R10: Status bit 0 means more than one result is held, and bit 1 means at least one is held. Bit 2 is a sticky overrun flag, set when a result arrives at a full results FIFO; that result is dropped.
- R11: After reset, the status reads 0x0020 (scan-list FIFO empty), and adc_start and all selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |
| adc_start | output | 1 | One-cycle conversion start |
| adc_done | input | 1 | Conversion complete |
| adc_data | input | 16 | Conversion result, valid with adc_done |
| sel_chan | output | 2 | Low channel select bits |
| sel_gain | output | 3 | Gain code |
| sel_bank_lo | output | 1 | Low bank enable |
| sel_bank_hi | output | 1 | High bank enable |
| sel_hilo | output | 1 | High/low select |
| sel_single | output | 1 | Single-ended (1) or differential (0) |

## Verification
The bench targets several corner cases:
- A stray single byte written before a scan-list FIFO reset. A design that did not clear the pending byte would shift every later entry and drive wrong selects.
- Pacer ticks with the pipe not yet started, which must not start any conversion.
- The quiet period after a last-flagged entry, during which a leaking design would restart the converter.
- Two chained entries whose start-to-start spacing must equal the divider period.
- Nine conversions into an eight-deep results FIFO. This checks that the overrun flag is set and stays set, and that the first eight samples come back in order.
- Reads of an empty results FIFO and done pulses with no pending conversion.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
  localparam int BUS_W   = 16;
  localparam int ADDR_W  = 8;
  localparam int PACE_W  = 48;

  localparam logic [ADDR_W-1:0] A_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] A_SCAN  = 8'h02;
  localparam logic [ADDR_W-1:0] A_PLO0  = 8'h04;
  localparam logic [ADDR_W-1:0] A_PLO1  = 8'h06;
  localparam logic [ADDR_W-1:0] A_PHI   = 8'h0A;
  localparam logic [ADDR_W-1:0] A_RES   = 8'h10;

  localparam logic [BUS_W-1:0] CMD_RUN      = 16'h0011;
  localparam logic [BUS_W-1:0] CMD_HALT     = 16'h0010;
  localparam logic [BUS_W-1:0] CMD_PACE_ON  = 16'h0031;
  localparam logic [BUS_W-1:0] CMD_PACE_OFF = 16'h0030;

  typedef struct packed {
    logic       last;
    logic [1:0] chan;
    logic [6:0] w3;
  } cfg_t;
endpackage

// File: rtl/acq_fifo.sv
module acq_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic             do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // R10: occupancy never exceeds the depth
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R9: a pop on an empty FIFO leaves it empty
  a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    empty && !push && !clr |=> empty);
endmodule

// File: rtl/acq_pacer.sv
module acq_pacer #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] div,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  assign tick = en && (cnt >= div);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt <= '0;
    else if (cnt >= div) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  // R4: each enable starts the period from zero
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> (cnt == '0));
endmodule

// File: rtl/acq_scan_seq.sv
module acq_scan_seq
  import acq_seq_pkg::*;
#(
  parameter int SCAN_DEPTH = 16,
  parameter int RES_DEPTH  = 8,
  localparam int SCW = $clog2(SCAN_DEPTH + 1),
  localparam int RCW = $clog2(RES_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        adc_start,
  input  logic        adc_done,
  input  logic [15:0] adc_data,
  output logic [1:0]  sel_chan,
  output logic [2:0]  sel_gain,
  output logic        sel_bank_lo,
  output logic        sel_bank_hi,
  output logic        sel_hilo,
  output logic        sel_single
);
  // control decode
  logic wr_ctrl, wr_scan, is_rst_cmd;
  logic clr_scan, clr_res, clr_pipe;
  assign wr_ctrl    = bus_wr && (bus_addr == A_CTRL);
  assign wr_scan    = bus_wr && (bus_addr == A_SCAN);
  assign is_rst_cmd = wr_ctrl && (bus_wdata[15:3] == '0);
  assign clr_scan   = is_rst_cmd && bus_wdata[2];
  assign clr_res    = is_rst_cmd && bus_wdata[1];
  assign clr_pipe   = is_rst_cmd && bus_wdata[0];

  // byte assembly into the scan list
  logic       byte_hi;
  logic [7:0] byte_lo;
  always_ff @(posedge clk) begin
    if (!rst_n || clr_scan) begin
      byte_hi <= 1'b0;
      byte_lo <= '0;
    end else if (wr_scan) begin
      byte_hi <= !byte_hi;
      if (!byte_hi) byte_lo <= bus_wdata[7:0];
    end
  end

  logic            scan_pop, scan_full, scan_empty;
  logic [15:0]     scan_dout;
  logic [SCW-1:0]  scan_cnt;
  acq_fifo #(.WIDTH(16), .DEPTH(SCAN_DEPTH)) u_scan_fifo (
    .clk, .rst_n, .clr(clr_scan),
    .push(wr_scan && byte_hi), .din({bus_wdata[7:0], byte_lo}),
    .pop(scan_pop), .dout(scan_dout),
    .full(scan_full), .empty(scan_empty), .count(scan_cnt));

  // pacer divider
  logic [PACE_W-1:0] pace_div;
  logic              pacer_en, tick;
  always_ff @(posedge clk) begin
    if (!rst_n) pace_div <= '0;
    else if (bus_wr) begin
      if (bus_addr == A_PLO0) pace_div[15:0]  <= bus_wdata;
      if (bus_addr == A_PLO1) pace_div[31:16] <= bus_wdata;
      if (bus_addr == A_PHI)  pace_div[47:32] <= bus_wdata;
    end
  end

  acq_pacer #(.CNT_W(PACE_W)) u_pacer (
    .clk, .rst_n, .en(pacer_en), .div(pace_div), .tick);

  // config pipe and sequencer
  cfg_t       cfg;
  logic [1:0] pipe_idx;
  logic       pipe_full, scan_run, scanning, halted, busy, cur_last;
  logic       accept, load_en, res_push;

  assign load_en  = scan_run && !pipe_full && !halted && !scan_empty;
  assign scan_pop = load_en;
  assign accept   = tick && pipe_full && scanning && !busy;
  assign res_push = busy && adc_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0; pipe_idx <= '0; pipe_full <= 1'b0; scan_run <= 1'b0;
      scanning <= 1'b0; halted <= 1'b0; busy <= 1'b0; cur_last <= 1'b0;
      pacer_en <= 1'b0; adc_start <= 1'b0;
      {sel_chan, sel_gain, sel_bank_lo, sel_bank_hi, sel_hilo, sel_single} <= '0;
    end else begin
      adc_start <= 1'b0;
      if (load_en) begin
        case (pipe_idx)
          2'd1:    cfg.last <= scan_dout[2];
          2'd2:    cfg.chan <= scan_dout[7:6];
          2'd3:    cfg.w3   <= scan_dout[6:0];
          default: ;
        endcase
        pipe_idx <= pipe_idx + 1'b1;
        if (pipe_idx == 2'd3) pipe_full <= 1'b1;
      end
      if (accept) begin
        adc_start   <= 1'b1;
        busy        <= 1'b1;
        cur_last    <= cfg.last;
        sel_chan    <= cfg.chan;
        sel_bank_lo <= cfg.w3[0];
        sel_bank_hi <= cfg.w3[1];
        sel_hilo    <= cfg.w3[2];
        sel_gain    <= cfg.w3[5:3];
        sel_single  <= cfg.w3[6];
      end
      if (res_push) begin
        busy      <= 1'b0;
        pipe_full <= 1'b0;
        if (cur_last) begin
          scanning <= 1'b0;
          halted   <= 1'b1;
        end
      end else if (pacer_en && pipe_full && !scanning && !halted) begin
        scanning <= 1'b1;
      end
      if (wr_ctrl) begin
        if (bus_wdata == CMD_RUN) scan_run <= 1'b1;
        if (bus_wdata == CMD_HALT) begin
          scan_run <= 1'b0; scanning <= 1'b0; halted <= 1'b0;
        end
        if (bus_wdata == CMD_PACE_ON) pacer_en <= 1'b1;
        if (bus_wdata == CMD_PACE_OFF) begin
          pacer_en <= 1'b0; scanning <= 1'b0; halted <= 1'b0;
        end
      end
      if (clr_pipe) begin
        pipe_idx <= '0; pipe_full <= 1'b0; busy <= 1'b0;
        scanning <= 1'b0; halted <= 1'b0;
      end
    end
  end

  // results
  logic           res_full, res_empty, overrun, res_pop;
  logic [15:0]    res_dout;
  logic [RCW-1:0] res_cnt;
  assign res_pop = bus_rd && (bus_addr == A_RES);

  acq_fifo #(.WIDTH(16), .DEPTH(RES_DEPTH)) u_res_fifo (
    .clk, .rst_n, .clr(clr_res),
    .push(res_push), .din(adc_data),
    .pop(res_pop), .dout(res_dout),
    .full(res_full), .empty(res_empty), .count(res_cnt));

  always_ff @(posedge clk) begin
    if (!rst_n || clr_res) overrun <= 1'b0;
    else if (res_push && res_full) overrun <= 1'b1;
  end

  logic [15:0] status;
  assign status = {10'd0, scan_empty, pipe_full, scanning, overrun,
                   !res_empty, (res_cnt > RCW'(1))};

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= status;
        A_RES:   bus_rdata <= res_empty ? 16'd0 : res_dout;
        default: bus_rdata <= '0;
      endcase
    end
  end

  logic unused_bits;
  assign unused_bits = ^{scan_full, scan_cnt};

  // R6: start is a single-cycle pulse
  a_r6_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  // R5: a conversion starts only from a full pipe while scanning
  a_r5_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> $past(pipe_full && scanning));
  // R8: after the last entry the sequencer is quiet
  a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !scanning && !adc_start);
  // R10: overrun holds until a results reset
  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overrun) && !$past(clr_res) |-> overrun);
endmodule

// File: tb/acq_scan_seq_bench.sv
module acq_scan_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        adc_start;
  logic        adc_done = 1'b0;
  logic [15:0] adc_data = '0;
  logic [1:0]  sel_chan;
  logic [2:0]  sel_gain;
  logic        sel_bank_lo, sel_bank_hi, sel_hilo, sel_single;

  int n_chk = 0, n_err = 0;
  longint cyc = 0;

  acq_scan_seq u_acq_scan_seq (.*);

  always #4 clk = !clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    #(8 * 100000);
    n_err++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  function automatic logic [8:0] exp_sel(input logic [15:0] w2, input logic [15:0] w3);
    return {w2[7:6], w3[5:3], w3[0], w3[1], w3[2], w3[6]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic put_word(input logic [15:0] w);
    logic [7:0] junk;
    junk = 8'($urandom);
    wr(8'h02, {junk, w[7:0]});
    junk = 8'($urandom);
    wr(8'h02, {junk, w[15:8]});
  endtask

  task automatic load_cfg(input logic [15:0] w1, input logic [15:0] w2, input logic [15:0] w3);
    put_word(16'($urandom));
    put_word(w1);
    put_word(w2);
    put_word(w3);
  endtask

  task automatic wait_start(output bit ok, output longint at);
    ok = 1'b0; at = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (adc_start) begin ok = 1'b1; at = cyc; break; end
    end
  endtask

  task automatic finish_conv(input logic [15:0] dat, input int dly);
    repeat (dly) @(negedge clk);
    adc_done = 1'b1; adc_data = dat;
    @(negedge clk);
    adc_done = 1'b0;
  endtask

  task automatic one_scan(input logic [15:0] w2, input logic [15:0] w3, input logic [15:0] dat);
    bit ok; longint at; int seen; logic [15:0] st;
    load_cfg(16'($urandom) | 16'h0004, w2, w3);
    wr(8'h00, 16'h0011);
    wr(8'h00, 16'h0031);
    wait_start(ok, at);
    chk("R6 start seen", 32'(ok), 32'd1);
    chk("R6/R1 selects", 32'({sel_chan, sel_gain, sel_bank_lo, sel_bank_hi, sel_hilo, sel_single}),
        32'(exp_sel(w2, w3)));
    @(negedge clk);
    chk("R6 pulse width", 32'(adc_start), 32'd0);
    finish_conv(dat, int'($urandom_range(0, 2)));
    seen = 0;
    repeat (16) begin @(negedge clk); if (adc_start) seen++; end
    chk("R8 no start after last", 32'(seen), 32'd0);
    rd(8'h00, st);
    chk("R8 scanning cleared", 32'(st[3]), 32'd0);
    chk("R7 result held", 32'(st[1]), 32'd1);
    wr(8'h00, 16'h0030);
    wr(8'h00, 16'h0010);
  endtask

  initial begin
    logic [15:0] st, d, w2, w3, dat, w2b, w3b;
    logic [15:0] exp_q[$];
    bit ok; longint t0, t1; int seen;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(8'h00, st);
    chk("R11 status after reset", 32'(st), 32'h0020);
    chk("R11 outputs after reset",
        32'({adc_start, sel_chan, sel_gain, sel_bank_lo, sel_bank_hi, sel_hilo, sel_single}), 32'd0);

    wr(8'h04, 16'd3); wr(8'h06, 16'd0); wr(8'h0A, 16'd0);

    // R5 ticks ignored without a started pipe
    load_cfg(16'h0004, 16'h00C0, 16'h0041);
    wr(8'h00, 16'h0031);
    seen = 0;
    repeat (30) begin @(negedge clk); if (adc_start) seen++; end
    chk("R5 no conversion without pipe", 32'(seen), 32'd0);
    rd(8'h00, st);
    chk("R5 status idle", 32'(st[4:3]), 32'd0);
    wr(8'h00, 16'h0030);
    wr(8'h00, 16'h0007);

    // R2 pipe fill and R3 pipe reset
    load_cfg(16'h0004, 16'h0040, 16'h0002);
    wr(8'h00, 16'h0011);
    repeat (4) @(negedge clk);
    rd(8'h00, st);
    chk("R2 pipe full, list drained", 32'(st[5:4]), 32'b11);
    wr(8'h00, 16'h0001);
    rd(8'h00, st);
    chk("R3 pipe reset", 32'(st[4:3]), 32'd0);
    wr(8'h00, 16'h0010);

    // R3 scan-list reset clears a dangling byte
    wr(8'h02, 16'h00AA);
    wr(8'h00, 16'h0004);
    one_scan(16'h0080, 16'h0045, 16'h1234);
    rd(8'h10, d);
    chk("R3/R9 result after byte reset", 32'(d), 32'h1234);

    // R7 stray done ignored
    finish_conv(16'hBEEF, 0);
    rd(8'h00, st);
    chk("R7 stray done ignored", 32'(st[1:0]), 32'd0);

    // random single-entry scans
    for (int k = 0; k < 12; k++) begin
      w2 = 16'($urandom); w3 = 16'($urandom); dat = 16'($urandom);
      one_scan(w2, w3, dat);
      rd(8'h10, d);
      chk("R7/R9 random result", 32'(d), 32'(dat));
    end

    // R8 chained entries, R4 period
    wr(8'h04, 16'd40);
    w2 = 16'($urandom); w3 = 16'($urandom);
    w2b = 16'($urandom); w3b = 16'($urandom);
    load_cfg(16'($urandom) & 16'hFFFB, w2, w3);
    load_cfg(16'($urandom) | 16'h0004, w2b, w3b);
    wr(8'h00, 16'h0011);
    wr(8'h00, 16'h0031);
    wait_start(ok, t0);
    chk("R8 first entry selects", 32'({sel_chan, sel_gain, sel_bank_lo, sel_bank_hi, sel_hilo, sel_single}),
        32'(exp_sel(w2, w3)));
    finish_conv(16'h0A0A, 0);
    wait_start(ok, t1);
    chk("R8 second entry started", 32'(ok), 32'd1);
    chk("R4 tick period D+1", 32'(t1 - t0), 32'd41);
    chk("R8 second entry selects", 32'({sel_chan, sel_gain, sel_bank_lo, sel_bank_hi, sel_hilo, sel_single}),
        32'(exp_sel(w2b, w3b)));
    finish_conv(16'h0B0B, 1);
    rd(8'h00, st);
    chk("R10 two results held", 32'(st[1:0]), 32'b11);
    rd(8'h10, d); chk("R9 first in order", 32'(d), 32'h0A0A);
    rd(8'h10, d); chk("R9 second in order", 32'(d), 32'h0B0B);
    wr(8'h00, 16'h0030); wr(8'h00, 16'h0010);
    wr(8'h04, 16'd3);

    // R10 overrun
    wr(8'h00, 16'h0007);
    for (int k = 0; k < 9; k++) begin
      dat = 16'($urandom);
      if (k < 8) exp_q.push_back(dat);
      one_scan(16'($urandom), 16'($urandom), dat);
    end
    rd(8'h00, st);
    chk("R10 full with overrun", 32'(st[2:0]), 32'b111);
    for (int k = 0; k < 8; k++) begin
      rd(8'h10, d);
      chk("R10 kept sample", 32'(d), 32'(exp_q.pop_front()));
    end
    rd(8'h10, d);
    chk("R9 empty read is zero", 32'(d), 32'd0);
    rd(8'h00, st);
    chk("R10 overrun sticky, empty", 32'(st[2:0]), 32'b100);
    wr(8'h00, 16'h0002);
    rd(8'h00, st);
    chk("R3 results reset clears overrun", 32'(st[2:0]), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule